// File: doc/BRIEF.md
# Host-Port Access Code Decoder and Address Formatter

This block sits between a host's external bus and a target's multiplexed host port. The host's four low address lines do not select a storage location. They carry an access code that names the kind of host-port cycle to run: an address cycle or a data cycle, and the space it goes to (data memory, program memory or I/O). One code instead returns a revision constant. The block decodes the code together with the transfer direction. From that decode it derives the cycle type and picks the memory select or the I/O select. It also sets the bus-driver enables, so that only the side that receives data is driven.

For address cycles, the host word is placed on a 17-bit target bus whose top bit is the high address line. The word is shifted to match the target's byte addressing: one bit for data memory and I/O, two bits for program memory. Data-cycle words pass through unshifted. Read data from the target is captured on a latch enable and presented to the host. A combination of code and direction that the target port does not define is flagged invalid. The block drives nothing for such an access, so the controller around it can acknowledge the host without touching the target.

Top module: `vaddr_fmt`

## Requirements
- R1: Codes 0, 2 and 4 written (rd_i=0) are valid address cycles for data memory, program memory and I/O respectively: valid_o=1, cyc_data_o=0.
- R2: Codes 1, 3 and 5 are valid data cycles in both directions for data memory, program memory and I/O respectively: valid_o=1, cyc_data_o=1. On a write, tgt_bus_o carries the host word zero-extended with no shift.
- R3: On an address cycle, tgt_bus_o = host word shifted left by 1 for data memory and I/O, and by 2 for program memory, truncated to 17 bits. Bit 16 is the high address line: data-memory word 0xFFFF gives 0x1FFFE, and program-memory word 0x7FFF gives 0x1FFFC.
- R4: sel_mem_o=1 for valid data- and program-memory accesses, and sel_io_o=1 for valid I/O accesses. At most one select is active, and neither is active for the version code or an invalid access.
- R5: Code 8 read is valid and returns the VERSION parameter (default 16'h0001) on host_rdata_o, with host_oe_o=1 and no select.
- R6: These accesses are invalid: a read of code 0, 2 or 4, a write of code 8, and any access to codes 6, 7 or 9–15. For them valid_o=0, no select, both output enables 0, host_rdata_o=0 and tgt_bus_o=0.
- R7: tgt_oe_o=1 only for valid writes, and host_oe_o=1 only for valid reads. The two are never active together. When tgt_oe_o=0, tgt_bus_o=0.
- R8: The read register loads tgt_rdata_i on a rising clock edge with rd_latch_i=1 and holds otherwise. It is zero after reset. Its value appears on host_rdata_o during valid data-cycle reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | 4 | Access code from host address lines |
| rd_i | input | 1 | 1 = host read, 0 = host write |
| host_wdata_i | input | 16 | Host write data / address word |
| tgt_rdata_i | input | 16 | Data returned by target bus |
| rd_latch_i | input | 1 | Capture enable for target read data |
| cyc_data_o | output | 1 | 1 = data cycle, 0 = address cycle |
| sel_mem_o | output | 1 | Memory-space select |
| sel_io_o | output | 1 | I/O-space select |
| tgt_bus_o | output | 17 | High address bit and multiplexed address/data to target |
| tgt_oe_o | output | 1 | Drive enable toward target |
| host_rdata_o | output | 16 | Read data toward host |
| host_oe_o | output | 1 | Drive enable toward host |
| valid_o | output | 1 | Access is a defined operation |

## Verification
The hardest case to reach is the read register holding stale target data while the decode moves to other codes. In that case a version read or an invalid read must not leak the held word, and a later data read must still show it. The stimulus captures a distinctive word with a one-cycle latch pulse and then changes the target input without latching. It then reads through the version code and an invalid code before returning to a data read. Truncation of the program-memory shift past bit 16 is reached with a word whose top bits are both set.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;
  typedef enum logic [1:0] {SPC_DM, SPC_PM, SPC_IO, SPC_NONE} space_e;

  typedef struct packed {
    space_e space;
    logic   addr_cyc;
    logic   data_cyc;
    logic   ver;
    logic   valid;
  } dec_t;
endpackage

// File: rtl/vaddr_decode.sv
module vaddr_decode
  import vaddr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] code_i,
  input  logic          rd_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o = '{space: SPC_NONE, addr_cyc: 1'b0, data_cyc: 1'b0, ver: 1'b0, valid: 1'b0};
    case (code_i)
      CW'(0): begin dec_o.space = SPC_DM; dec_o.addr_cyc = 1'b1; end
      CW'(1): begin dec_o.space = SPC_DM; dec_o.data_cyc = 1'b1; end
      CW'(2): begin dec_o.space = SPC_PM; dec_o.addr_cyc = 1'b1; end
      CW'(3): begin dec_o.space = SPC_PM; dec_o.data_cyc = 1'b1; end
      CW'(4): begin dec_o.space = SPC_IO; dec_o.addr_cyc = 1'b1; end
      CW'(5): begin dec_o.space = SPC_IO; dec_o.data_cyc = 1'b1; end
      CW'(8): dec_o.ver = 1'b1;
      default: ;
    endcase
    // address cycles are write-only, version is read-only
    dec_o.valid = (dec_o.addr_cyc & ~rd_i) | dec_o.data_cyc | (dec_o.ver & rd_i);
  end
endmodule

// File: rtl/vaddr_shift.sv
module vaddr_shift
  import vaddr_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DM_SHIFT = 1,
  parameter int PM_SHIFT = 2,
  localparam int BW      = DW + 1
) (
  input  space_e        space_i,
  input  logic          addr_cyc_i,
  input  logic [DW-1:0] data_i,
  output logic [BW-1:0] bus_o
);
  logic [BW-1:0] ext;
  assign ext = {1'b0, data_i};

  always_comb begin
    bus_o = ext;
    if (addr_cyc_i) begin
      case (space_i)
        SPC_PM:  bus_o = ext << PM_SHIFT;
        SPC_DM,
        SPC_IO:  bus_o = ext << DM_SHIFT;
        default: bus_o = ext;
      endcase
    end
  end
endmodule

// File: rtl/vaddr_rdlatch.sv
module vaddr_rdlatch #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  p_latch_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i));
endmodule

// File: rtl/vaddr_fmt.sv
module vaddr_fmt
  import vaddr_pkg::*;
#(
  parameter int          CW       = 4,
  parameter int          DW       = 16,
  parameter logic [15:0] VERSION  = 16'h0001,
  parameter int          DM_SHIFT = 1,
  parameter int          PM_SHIFT = 2,
  localparam int         BW       = DW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] code_i,
  input  logic          rd_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic [DW-1:0] tgt_rdata_i,
  input  logic          rd_latch_i,
  output logic          cyc_data_o,
  output logic          sel_mem_o,
  output logic          sel_io_o,
  output logic [BW-1:0] tgt_bus_o,
  output logic          tgt_oe_o,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_oe_o,
  output logic          valid_o
);
  dec_t          dec;
  logic [BW-1:0] shifted;
  logic [DW-1:0] rd_q;

  vaddr_decode #(.CW(CW)) u_dec (
    .code_i(code_i), .rd_i(rd_i), .dec_o(dec)
  );

  vaddr_shift #(.DW(DW), .DM_SHIFT(DM_SHIFT), .PM_SHIFT(PM_SHIFT)) u_shift (
    .space_i(dec.space), .addr_cyc_i(dec.addr_cyc), .data_i(host_wdata_i), .bus_o(shifted)
  );

  vaddr_rdlatch #(.DW(DW)) u_rdl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_latch_i), .d_i(tgt_rdata_i), .q_o(rd_q)
  );

  assign valid_o    = dec.valid;
  assign cyc_data_o = dec.valid & dec.data_cyc;
  assign sel_mem_o  = dec.valid & (dec.space == SPC_DM || dec.space == SPC_PM);
  assign sel_io_o   = dec.valid & (dec.space == SPC_IO);
  assign tgt_oe_o   = dec.valid & ~rd_i;
  assign host_oe_o  = dec.valid & rd_i;
  assign tgt_bus_o  = tgt_oe_o ? shifted : '0;

  always_comb begin
    host_rdata_o = '0;
    if (host_oe_o) host_rdata_o = dec.ver ? VERSION[DW-1:0] : rd_q;
  end

  p_oe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tgt_oe_o && host_oe_o));
  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_mem_o, sel_io_o}));
  p_invalid_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!tgt_oe_o && !host_oe_o && !sel_mem_o && !sel_io_o && host_rdata_o == '0));
  p_bus_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_oe_o |-> tgt_bus_o == '0);
  p_pm_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_oe_o && !cyc_data_o && code_i == CW'(2)) |-> tgt_bus_o[1:0] == 2'b00);
  p_dmio_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_oe_o && !cyc_data_o && (code_i == CW'(0) || code_i == CW'(4))) |-> !tgt_bus_o[0]);
endmodule

// File: tb/vaddr_fmt_bench.sv
module vaddr_fmt_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  code;
    logic        rd;
    logic [15:0] wdata;
    logic        valid;
    logic        cyc;
    logic        mem;
    logic        io;
    logic        toe;
    logic        hoe;
    logic [16:0] bus;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h1FFFE}, // R1 R3
    '{4'd2,  1'b0, 16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h1FFFC}, // R1 R3
    '{4'd2,  1'b0, 16'hC001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h10004}, // R3 truncation
    '{4'd4,  1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 17'h02468}, // R1 R3 R4
    '{4'd4,  1'b0, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 17'h10000}, // R3
    '{4'd1,  1'b0, 16'hABCD, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 17'h0ABCD}, // R2
    '{4'd3,  1'b0, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 17'h08001}, // R2
    '{4'd5,  1'b0, 16'h00FF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 17'h000FF}, // R2 R4
    '{4'd1,  1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 17'h00000}, // R2 R7
    '{4'd3,  1'b1, 16'h1111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 17'h00000}, // R2 R7
    '{4'd5,  1'b1, 16'h2222, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 17'h00000}, // R2 R7
    '{4'd8,  1'b1, 16'h3333, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 17'h00000}, // R5
    '{4'd0,  1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd2,  1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd4,  1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd8,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd6,  1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd7,  1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd9,  1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    '{4'd15, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00000}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  code = '0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] tdata = '0;
  logic        rd_latch = 1'b0;
  logic        cyc_data, sel_mem, sel_io, tgt_oe, host_oe, valid;
  logic [16:0] tgt_bus;
  logic [15:0] host_rdata;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_fmt u_vaddr_fmt (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .rd_i(rd),
    .host_wdata_i(wdata), .tgt_rdata_i(tdata), .rd_latch_i(rd_latch),
    .cyc_data_o(cyc_data), .sel_mem_o(sel_mem), .sel_io_o(sel_io),
    .tgt_bus_o(tgt_bus), .tgt_oe_o(tgt_oe), .host_rdata_o(host_rdata),
    .host_oe_o(host_oe), .valid_o(valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic r);
    @(negedge clk);
    code = c; rd = r;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset: read register is zero
    drive(4'd1, 1'b1);
    check("R8 reset rdata", 32'(host_rdata), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      code = VECS[i].code; rd = VECS[i].rd; wdata = VECS[i].wdata;
      #1;
      check("R6 valid", 32'(valid), 32'(VECS[i].valid));
      check("R1 R2 cycle", 32'(cyc_data), 32'(VECS[i].cyc));
      check("R4 sel_mem", 32'(sel_mem), 32'(VECS[i].mem));
      check("R4 sel_io", 32'(sel_io), 32'(VECS[i].io));
      check("R7 tgt_oe", 32'(tgt_oe), 32'(VECS[i].toe));
      check("R7 host_oe", 32'(host_oe), 32'(VECS[i].hoe));
      check("R3 tgt_bus", 32'(tgt_bus), 32'(VECS[i].bus));
      if (VECS[i].code == 4'd8 && VECS[i].rd)
        check("R5 version", 32'(host_rdata), 32'h0001);
      else
        check("R6 R8 host_rdata", 32'(host_rdata), 32'h0);
    end

    // R8 capture on latch pulse
    @(negedge clk);
    tdata = 16'h5A5A; rd_latch = 1'b1;
    @(negedge clk);
    rd_latch = 1'b0; tdata = 16'hC3C3;
    code = 4'd3; rd = 1'b1;
    #1;
    check("R8 captured", 32'(host_rdata), 32'h5A5A);
    repeat (2) @(negedge clk);
    #1;
    check("R8 held", 32'(host_rdata), 32'h5A5A);

    // R5 version not masked by held data; R6 invalid read shows nothing
    drive(4'd8, 1'b1);
    check("R5 version over held", 32'(host_rdata), 32'h0001);
    drive(4'd0, 1'b1);
    check("R6 invalid read quiet", 32'(host_rdata), 32'h0);
    check("R6 invalid host_oe", 32'(host_oe), 32'h0);
    drive(4'd5, 1'b1);
    check("R8 still held", 32'(host_rdata), 32'h5A5A);

    // R8 reload with new value
    @(negedge clk);
    rd_latch = 1'b1;
    @(negedge clk);
    rd_latch = 1'b0;
    #1;
    check("R8 reload", 32'(host_rdata), 32'hC3C3);

    // R8 reset clears register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    code = 4'd1; rd = 1'b1;
    #1;
    check("R8 cleared by reset", 32'(host_rdata), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule